// File: doc/BRIEF.md
# Mono I2S Sample Receiver

This block takes the three wires of an I2S serial audio link and produces one signed 18-bit sample per stereo frame. The link has a word-select line, a bit clock and a data line. Word select toggles once per channel at the sample rate Fs, which is 48, 96 or 192 kHz. The bit clock runs at 64·Fs, so each channel gets a 32-bit slot, sent most significant bit first.

All three lines are brought into a faster system clock through a synchroniser chain. Rising edges of the bit clock are then found by edge detection inside the system domain. A slot counter restarts on every word-select transition. The first 18 bits after that transition are shifted in, and the rest of the slot is discarded.

A single select input chooses whether the left or the right channel is delivered. A new selection is only adopted at the start of a frame, so a sample is never built from a mix of channels or from a slot cut short.

Top module: `mono_i2s_rx`

## Requirements
- R1: While reset is held and right after it, `sampleValid` is 0 and `sampleOut` is 0.
- R2: After a word-select transition, the data bit sampled on the first bit-clock rising edge belongs to the previous slot. The next 18 rising edges carry the sample MSB first, so `sampleOut` equals bits 31..14 of the 32-bit slot word, read as two's complement.
- R3: The 14 trailing bits of a slot (word bits 13..0) have no effect on `sampleOut`.
- R4: Word select low marks the left slot and high marks the right slot. With an effective select of 0 only left slots are delivered; with 1 only right slots are delivered.
- R5: Each selected, complete slot yields exactly one `sampleValid` pulse, and unselected slots yield none.
- R6: `sampleValid` is high for exactly one system clock cycle at a time.
- R7: A change of `selRight` becomes effective at the next word-select falling edge (frame start). The frame in progress is still delivered from the channel that was selected when it began.
- R8: After reset, no sample is produced until the first word-select transition has been seen.
- R9: `sampleOut` keeps its value between `sampleValid` pulses.
- R10: A selected slot that ends (word select toggles) before 18 data bits have arrived produces no sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| i2sSck | input | 1 | I2S bit clock, asynchronous to clk |
| i2sWs | input | 1 | I2S word select: 0 left, 1 right |
| i2sSd | input | 1 | I2S serial data |
| selRight | input | 1 | Channel choice: 0 left, 1 right; adopted at frame start |
| sampleOut | output | 18 | Last delivered signed sample |
| sampleValid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The hardest cases to reach from the ports are the ones where a selected slot must be thrown away. One is a select change made while a frame is in flight; the other is a slot cut short by an early word-select toggle. The driver builds frames bit by bit, so it can flip `selRight` ten bits into a left slot. It can also truncate a right slot to ten bit periods. The scoreboard predicts from the selection at frame start and the slot length, and it flags any extra or missing strobe. Leading idle bits after each reset, with word select held steady, show that nothing is emitted before a boundary has been seen.

// File: rtl/mono_i2s_rx_pkg.sv
package mono_i2s_rx_pkg;

  // Strobes issued by the slot controller to the sample datapath.
  typedef struct packed {
    logic clearShift;  // new slot begins: empty the shift register
    logic shiftEn;     // capture the current data bit
    logic lastBit;     // this capture completes the sample
  } rxStrobe_t;

endpackage

// File: rtl/mono_i2s_rx_sync.sv
module mono_i2s_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic wsIn,
  input  logic sdIn,
  output logic wsOut,
  output logic sdOut,
  output logic sckRise
);

  localparam int LINES = 3;

  logic [LINES-1:0] pipe [STAGES];
  logic             sckPrev;

  always_ff @(posedge clk) begin
    if (!rstN) pipe[0] <= '0;
    else       pipe[0] <= {sckIn, wsIn, sdIn};
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : gStage
      always_ff @(posedge clk) begin
        if (!rstN) pipe[s] <= '0;
        else       pipe[s] <= pipe[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= pipe[STAGES-1][2];
  end

  assign wsOut   = pipe[STAGES-1][1];
  assign sdOut   = pipe[STAGES-1][0];
  assign sckRise = pipe[STAGES-1][2] & ~sckPrev;

endmodule

// File: rtl/mono_i2s_rx_ctrl.sv
module mono_i2s_rx_ctrl
  import mono_i2s_rx_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  parameter int KEEP_BITS = 18
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sckRise,
  input  logic      wsBit,
  input  logic      selRight,
  output rxStrobe_t strobe
);

  localparam int CW = $clog2(SLOT_BITS + 1);
  localparam logic [CW-1:0] IDLE_CNT = CW'(SLOT_BITS);
  localparam logic [CW-1:0] KEEP_CNT = CW'(KEEP_BITS);

  logic          seenWs;
  logic          wsLast;
  logic          slotCh;
  logic          selActive;
  logic [CW-1:0] bitCnt;
  logic          boundary;
  logic          inSelected;

  assign boundary   = sckRise && seenWs && (wsBit != wsLast);
  assign inSelected = (slotCh == selActive) && (bitCnt < KEEP_CNT);

  always_comb begin
    strobe            = '0;
    strobe.clearShift = boundary;
    strobe.shiftEn    = sckRise && seenWs && !boundary && inSelected;
    strobe.lastBit    = strobe.shiftEn && (bitCnt == KEEP_CNT - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenWs    <= 1'b0;
      wsLast    <= 1'b0;
      slotCh    <= 1'b0;
      selActive <= 1'b0;
      bitCnt    <= IDLE_CNT;
    end else if (sckRise) begin
      if (!seenWs) begin
        seenWs <= 1'b1;
        wsLast <= wsBit;
      end else if (boundary) begin
        wsLast <= wsBit;
        slotCh <= wsBit;
        bitCnt <= '0;
        if (!wsBit) selActive <= selRight;
      end else if (bitCnt < IDLE_CNT) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // R8: nothing is captured before a word-select level has been learned
  a_r8_no_capture_unaligned: assert property (@(posedge clk) disable iff (!rstN)
    !seenWs |-> !strobe.shiftEn);

  // R2: the slot counter never passes the slot length
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= IDLE_CNT);

  // R7: the active selection only moves on a slot start into the left channel
  a_r7_sel_frame_only: assert property (@(posedge clk) disable iff (!rstN)
    !(boundary && !wsBit) |=> $stable(selActive));

  // R10: a boundary never coincides with a capture
  a_r10_boundary_no_shift: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearShift |-> !strobe.shiftEn);

endmodule

// File: rtl/mono_i2s_rx_dpath.sv
module mono_i2s_rx_dpath
  import mono_i2s_rx_pkg::*;
#(
  parameter int KEEP_BITS = 18
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobe_t            strobe,
  input  logic                 sdBit,
  output logic [KEEP_BITS-1:0] sample,
  output logic                 valid
);

  logic [KEEP_BITS-2:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.clearShift) begin
      shiftReg <= '0;
    end else if (strobe.shiftEn) begin
      shiftReg <= {shiftReg[KEEP_BITS-3:0], sdBit};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sample <= '0;
      valid  <= 1'b0;
    end else begin
      valid <= strobe.lastBit;
      if (strobe.lastBit) sample <= {shiftReg, sdBit};
    end
  end

  // R6: strobe is a single cycle wide
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> !valid);

  // R9: output holds between strobes
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.lastBit |=> $stable(sample));

endmodule

// File: rtl/mono_i2s_rx.sv
module mono_i2s_rx
  import mono_i2s_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SLOT_BITS   = 32,
  parameter int KEEP_BITS   = 18
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 i2sSck,
  input  logic                 i2sWs,
  input  logic                 i2sSd,
  input  logic                 selRight,
  output logic [KEEP_BITS-1:0] sampleOut,
  output logic                 sampleValid
);

  logic      wsSync;
  logic      sdSync;
  logic      sckRise;
  rxStrobe_t strobe;

  mono_i2s_rx_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sckIn(i2sSck), .wsIn(i2sWs), .sdIn(i2sSd),
    .wsOut(wsSync), .sdOut(sdSync), .sckRise(sckRise)
  );

  mono_i2s_rx_ctrl #(.SLOT_BITS(SLOT_BITS), .KEEP_BITS(KEEP_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .sckRise(sckRise), .wsBit(wsSync),
    .selRight(selRight), .strobe(strobe)
  );

  mono_i2s_rx_dpath #(.KEEP_BITS(KEEP_BITS)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdBit(sdSync),
    .sample(sampleOut), .valid(sampleValid)
  );

endmodule

// File: tb/mono_i2s_rx_test.sv
module mono_i2s_rx_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        i2sSck = 1'b0;
  logic        i2sWs = 1'b1;
  logic        i2sSd = 1'b0;
  logic        selRight = 1'b0;
  logic [17:0] sampleOut;
  logic        sampleValid;

  int    checks = 0;
  int    fails = 0;
  string phase = "R8";
  logic  prevLsb = 1'b0;
  logic  lastValid = 1'b0;
  logic [17:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  mono_i2s_rx uut (
    .clk(clk), .rstN(rstN), .i2sSck(i2sSck), .i2sWs(i2sWs), .i2sSd(i2sSd),
    .selRight(selRight), .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares each strobe with the scoreboard head, away from the edge.
  always @(negedge clk) begin
    if (rstN) begin
      if (sampleValid && lastValid) check(1'b0, "R6", 32'd2, 32'd1);
      if (sampleValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, phase, {14'd0, sampleOut}, 32'hxxxx);
        end else begin
          logic [17:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(sampleOut === e, t, {14'd0, sampleOut}, {14'd0, e});
        end
      end
    end
    lastValid <= sampleValid;
  end

  task automatic bitPeriod(input logic ws, input logic sd);
    i2sWs = ws;
    i2sSd = sd;
    #40 i2sSck = 1'b1;
    #40 i2sSck = 1'b0;
  endtask

  task automatic idleBits(input int n);
    for (int i = 0; i < n; i++) bitPeriod(1'b1, 1'(i % 3 == 0));
  endtask

  task automatic sendSlot(input logic ch, input logic [31:0] word, input int len,
                          input bit doSwitch, input logic newSel);
    for (int i = 0; i < len; i++) begin
      if (doSwitch && i == 10) selRight = newSel;
      bitPeriod(ch, (i == 0) ? prevLsb : word[32-i]);
    end
    prevLsb = word[0];
  endtask

  // Driver: pushes the expected sample, then sends a left and a right slot.
  task automatic sendFrame(input logic [31:0] l, input logic [31:0] r, input int lenR,
                           input bit doSwitch, input logic newSel, input string tag);
    if (!selRight) begin
      expQ.push_back(l[31:14]); tagQ.push_back(tag);
    end else if (lenR >= 19) begin
      expQ.push_back(r[31:14]); tagQ.push_back(tag);
    end
    sendSlot(1'b0, l, 32, doSwitch, newSel);
    sendSlot(1'b1, r, lenR, 1'b0, 1'b0);
  endtask

  task automatic applyReset();
    rstN = 1'b0;
    repeat (4) @(posedge clk);
    #2;
    check(sampleValid === 1'b0, "R1", {31'd0, sampleValid}, 32'd0);
    check(sampleOut === 18'd0, "R1", {14'd0, sampleOut}, 32'd0);
    rstN = 1'b1;
    #1;
  endtask

  initial begin
    fork
      begin
        #2;
        applyReset();
        // R8: word select held high with data toggling, selRight=1: no sample
        phase = "R8";
        selRight = 1'b1;
        idleBits(40);
        #200;
        check(expQ.size() == 0, "R8", 32'(expQ.size()), 32'd0);
        selRight = 1'b0;
        idleBits(2);
        // R2/R4: left channel, several patterns
        phase = "R2";
        sendFrame(32'h8000_0000, 32'h1234_5678, 32, 0, 0, "R2");
        sendFrame(32'h7FFF_C000, 32'hFFFF_FFFF, 32, 0, 0, "R2");
        sendFrame(32'hA5A5_A5A5, 32'h5A5A_5A5A, 32, 0, 0, "R4");
        // R3: same top 18 bits, different low bits
        sendFrame(32'h1357_8000, 32'h0, 32, 0, 0, "R3");
        sendFrame(32'h1357_BFFF, 32'h0, 32, 0, 0, "R3");
        // R7: switch to right while the left slot is in flight
        phase = "R7";
        sendFrame(32'hDEAD_BEEF, 32'hCAFE_F00D, 32, 1, 1'b1, "R7");
        // R4/R5: right channel now effective
        phase = "R5";
        sendFrame(32'h0F0F_0F0F, 32'hFFFC_0000, 32, 0, 0, "R4");
        sendFrame(32'h1111_1111, 32'h0003_FFFF, 32, 0, 0, "R5");
        // R10: short right slot yields nothing, next frame recovers
        phase = "R10";
        sendFrame(32'h2222_2222, 32'h9999_9999, 10, 0, 0, "R10");
        sendFrame(32'h3333_3333, 32'h4000_4000, 32, 0, 0, "R10");
        // R7: switch back to left mid-frame; this frame still delivers right
        phase = "R7";
        sendFrame(32'h6666_6666, 32'h7777_7777, 32, 1, 1'b0, "R7");
        sendFrame(32'hC000_0001, 32'h8888_8888, 32, 0, 0, "R7");
        bitPeriod(1'b0, prevLsb);
        #400;
        check(expQ.size() == 0, "R5", 32'(expQ.size()), 32'd0);
        // R1: reset mid-run, then R8 again before resuming
        applyReset();
        phase = "R8";
        idleBits(6);
        phase = "R2";
        sendFrame(32'hFEDC_BA98, 32'h0, 32, 0, 0, "R2");
        bitPeriod(1'b0, prevLsb);
        #400;
        check(expQ.size() == 0, "R5", 32'(expQ.size()), 32'd0);
      end
      begin
        #1_500_000;
        check(1'b0, "watchdog", 32'd0, 32'd1);
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule